// File: doc/BRIEF.md
# Boot-Protected Flash Array Model

A behavioural flash storage block meant to sit behind a command controller in a larger system model. It holds a byte-addressed array split into five erase regions of unequal size: a two-unit boot region, two one-unit parameter regions, a twelve-unit small main region and a sixteen-unit large main region. A unit is `2**UNIT_LG` bytes, so the array always spans 32 units. A parameter chooses whether the boot region sits at the high or the low end of the address space. The regions in between are mirrored to match.

The controller issues one request at a time. A request is either a byte or word program, or an erase of the region containing the request address. A program can only clear bits. An erase returns the whole addressed region to all ones. The boot region is locked unless a high-voltage unlock flag or a write-protect-release input is asserted. All regions also need the programming supply to be good. A request that fails these checks is refused at once with an error pulse. An accepted operation keeps `busy` high for a fixed number of cycles and then ends with a one-cycle `done`. The array can be read at any time through a separate combinational read port.

Top module: `fbk_flash_array`

## Requirements
- R1: After reset, `busy`, `done`, `prog_err` and `erase_err` are all low.
- R2: With `TOP_BOOT`=1, the regions are as follows, in units: boot is 30–31, parameter regions are 29 and 28, small main is 16–27 and large main is 0–15. An erase changes exactly the addressed region.
- R3: With `TOP_BOOT`=0, the regions are as follows, in units: boot is 0–1, parameter regions are 2 and 3, small main is 4–15 and large main is 16–31. An erase changes exactly the addressed region.
- R4: A program stores the old byte ANDed with the new data, so bits can only go from 1 to 0.
- R5: An erase (`req_op`=2) sets every byte of the addressed region to FFh and leaves all other bytes unchanged.
- R6: A program or erase that targets the boot region is refused unless `unlock_hv` or `wp_hi` is high. A refused request causes no `busy`. One cycle after acceptance it raises `done` together with `prog_err` (program) or `erase_err` (erase), and the array is unchanged.
- R7: For a boot-region operation, the unlock condition must hold on every cycle until completion. If it lapses, the operation completes on time with its error flag set and writes nothing.
- R8: With `vpp_ok` low, every program or erase, in any region, is refused as in R6.
- R9: An accepted program (`req_op`=1) holds `busy` high for exactly `PROG_CYCLES` cycles, and an erase for `ERASE_CYCLES` cycles. A single-cycle `done` follows in the cycle `busy` falls.
- R10: Requests that arrive while `busy` is high are ignored. Op codes 0 and 3 are ignored at any time: they produce no `busy` and no `done`, and change nothing.
- R11: With `req_word`=1, a program writes `req_data[7:0]` to the even byte and `req_data[15:8]` to the odd byte of the pair selected by `req_addr` with bit 0 ignored. With `rd_word`=1 the read returns `{odd byte, even byte}`; otherwise it returns `{8'h00, byte}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 2 | 1 = program, 2 = erase region, 0/3 ignored |
| req_addr | input | UNIT_LG+5 | Byte address of the request |
| req_word | input | 1 | Program a 16-bit word instead of a byte |
| req_data | input | 16 | Program data |
| vpp_ok | input | 1 | Programming supply valid |
| unlock_hv | input | 1 | High-voltage unlock flag for the boot region |
| wp_hi | input | 1 | Write-protect release for the boot region |
| rd_addr | input | UNIT_LG+5 | Read byte address |
| rd_word | input | 1 | Read a word instead of a byte |
| rd_data | output | 16 | Read data, combinational |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion or refusal pulse |
| prog_err | output | 1 | Program refused or aborted, with `done` |
| erase_err | output | 1 | Erase refused or aborted, with `done` |

## Verification
A wrong region decode shows in the first read-back after an erase: bytes just outside the region come back as FFh, or bytes just inside stay cleared. Bytes next to each region boundary are swept after erases under both boot placements, so such a fault is caught. A latency counter that is off by one shows as a wrong `busy` count in the first operation. A stale lock or supply flag shows on the same operation as a missing or extra error pulse, and in the read-back that follows. A request that was wrongly accepted while busy appears at once as changed data at the injected address.

// File: rtl/fbk_pkg.sv
// Shared types for the boot-protected flash array model.
package fbk_pkg;

    // Request operation codes seen on req_op.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } fbk_op_e;

    // Erase regions, independent of their placement.
    typedef enum logic [2:0] {
        REG_BOOT    = 3'd0,
        REG_PARAM_A = 3'd1,
        REG_PARAM_B = 3'd2,
        REG_MAIN_S  = 3'd3,
        REG_MAIN_L  = 3'd4
    } fbk_region_e;

    // Region sizes in units; they always total UNITS_TOTAL.
    localparam int UNITS_TOTAL  = 32;
    localparam int UNITS_BOOT   = 2;
    localparam int UNITS_PARAM  = 1;
    localparam int UNITS_MAIN_S = 12;
    localparam int UNITS_MAIN_L = 16;

endpackage

// File: rtl/fbk_region_map.sv
// Region decoder: maps a byte address to its erase region, base unit and
// span in units. Assumes the address is exactly UNIT_LG+5 bits wide.
// TOP_BOOT selects the high-end or low-end boot placement.
module fbk_region_map
    import fbk_pkg::*;
#(
    parameter int UNIT_LG  = 6,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [UNIT_LG+4:0] addr,
    output fbk_region_e        region,
    output logic [4:0]         base_unit,
    output logic [4:0]         span_units
);

    logic [4:0] unit;
    assign unit = addr[UNIT_LG+4:UNIT_LG];

    generate
        if (TOP_BOOT) begin : g_top
            // High-end boot: boot at top, main regions grow from zero.
            always_comb begin
                if (unit >= 5'd30) begin
                    region = REG_BOOT;    base_unit = 5'd30; span_units = 5'(UNITS_BOOT);
                end else if (unit == 5'd29) begin
                    region = REG_PARAM_A; base_unit = 5'd29; span_units = 5'(UNITS_PARAM);
                end else if (unit == 5'd28) begin
                    region = REG_PARAM_B; base_unit = 5'd28; span_units = 5'(UNITS_PARAM);
                end else if (unit >= 5'd16) begin
                    region = REG_MAIN_S;  base_unit = 5'd16; span_units = 5'(UNITS_MAIN_S);
                end else begin
                    region = REG_MAIN_L;  base_unit = 5'd0;  span_units = 5'(UNITS_MAIN_L);
                end
            end
        end else begin : g_bottom
            // Low-end boot: boot at zero, large main region at top.
            always_comb begin
                if (unit < 5'd2) begin
                    region = REG_BOOT;    base_unit = 5'd0;  span_units = 5'(UNITS_BOOT);
                end else if (unit == 5'd2) begin
                    region = REG_PARAM_A; base_unit = 5'd2;  span_units = 5'(UNITS_PARAM);
                end else if (unit == 5'd3) begin
                    region = REG_PARAM_B; base_unit = 5'd3;  span_units = 5'(UNITS_PARAM);
                end else if (unit < 5'd16) begin
                    region = REG_MAIN_S;  base_unit = 5'd4;  span_units = 5'(UNITS_MAIN_S);
                end else begin
                    region = REG_MAIN_L;  base_unit = 5'd16; span_units = 5'(UNITS_MAIN_L);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fbk_guard.sv
// Permission guard: decides whether a new request may start and tracks
// whether the supply and (for boot operations) the unlock held on every
// cycle of the running operation. Assumes start only pulses when idle.
module fbk_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic req_boot,
    input  logic busy,
    input  logic vpp_ok,
    input  logic unlock_hv,
    input  logic wp_hi,
    output logic req_allowed,
    output logic end_ok
);

    logic boot_q;
    logic held_q;
    logic op_cond;

    // Permission for an incoming request.
    assign req_allowed = vpp_ok && (!req_boot || unlock_hv || wp_hi);
    // Permission for the operation in flight, this cycle.
    assign op_cond     = vpp_ok && (!boot_q || unlock_hv || wp_hi);
    // Valid at the completion edge only if it never lapsed.
    assign end_ok      = held_q && op_cond;

    // Latch boot target at start; clear the hold flag on any lapse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
            held_q <= 1'b0;
        end else if (start) begin
            boot_q <= req_boot;
            held_q <= 1'b1;
        end else if (busy && !op_cond) begin
            held_q <= 1'b0;
        end
    end

    // R7: once lapsed, the hold flag cannot recover mid-operation.
    a_r7_no_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !held_q && !start) |=> !held_q);

endmodule

// File: rtl/fbk_op_timer.sv
// Latency counter: holds busy for PROG_CYCLES or ERASE_CYCLES cycles after
// start and flags the final cycle. Assumes both counts are at least 1.
module fbk_op_timer #(
    parameter int PROG_CYCLES  = 3,
    parameter int ERASE_CYCLES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_erase,
    output logic busy,
    output logic last
);

    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);
    assign last = (cnt == CW'(1));

    // Load the latency at start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= start_erase ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // R10: a new operation never starts on top of a running one.
    a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R9: the counter never exceeds the longest latency.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXC));

endmodule

// File: rtl/fbk_flash_array.sv
// Boot-protected flash array model. Accepts one program or erase at a time,
// applies AND-only programming and whole-region erase at completion, and
// refuses boot-region changes without an unlock. Array contents are not
// reset (non-volatile); control state uses synchronous active-low reset.
module fbk_flash_array
    import fbk_pkg::*;
#(
    parameter int UNIT_LG      = 6,
    parameter bit TOP_BOOT     = 1'b1,
    parameter int PROG_CYCLES  = 3,
    parameter int ERASE_CYCLES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [UNIT_LG+4:0] req_addr,
    input  logic               req_word,
    input  logic [15:0]        req_data,
    input  logic               vpp_ok,
    input  logic               unlock_hv,
    input  logic               wp_hi,
    input  logic [UNIT_LG+4:0] rd_addr,
    input  logic               rd_word,
    output logic [15:0]        rd_data,
    output logic               busy,
    output logic               done,
    output logic               prog_err,
    output logic               erase_err
);

    localparam int AW        = UNIT_LG + 5;
    localparam int MEM_BYTES = 1 << AW;

    logic [7:0] mem [MEM_BYTES];

    fbk_op_e     op_in;
    fbk_region_e region;
    logic [4:0]  base_unit;
    logic [4:0]  span_units;
    logic        req_boot, valid_op, accept, launch, reject;
    logic        req_allowed, end_ok, finish, commit;

    fbk_op_e     op_q;
    fbk_region_e region_q;
    logic [AW-1:0] addr_q;
    logic          word_q;
    logic [15:0]   data_q;
    logic [AW:0]   lo_q, hi_q;

    logic [AW-1:0] even_q, odd_q, rd_even, rd_odd;

    assign op_in    = fbk_op_e'(req_op);
    assign valid_op = (op_in == OP_PROG) || (op_in == OP_ERASE);
    assign req_boot = (region == REG_BOOT);
    assign accept   = req_valid && valid_op && !busy;
    assign launch   = accept && req_allowed;
    assign reject   = accept && !req_allowed;
    assign commit   = finish && end_ok;

    fbk_region_map #(.UNIT_LG(UNIT_LG), .TOP_BOOT(TOP_BOOT)) u_map (
        .addr       (req_addr),
        .region     (region),
        .base_unit  (base_unit),
        .span_units (span_units)
    );

    fbk_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (launch),
        .req_boot    (req_boot),
        .busy        (busy),
        .vpp_ok      (vpp_ok),
        .unlock_hv   (unlock_hv),
        .wp_hi       (wp_hi),
        .req_allowed (req_allowed),
        .end_ok      (end_ok)
    );

    fbk_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (launch),
        .start_erase (op_in == OP_ERASE),
        .busy        (busy),
        .last        (finish)
    );

    // Capture the request and its region bounds when it launches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            region_q <= REG_MAIN_L;
            addr_q   <= '0;
            word_q   <= 1'b0;
            data_q   <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else if (launch) begin
            op_q     <= op_in;
            region_q <= region;
            addr_q   <= req_addr;
            word_q   <= req_word;
            data_q   <= req_data;
            lo_q     <= {1'b0, base_unit, {UNIT_LG{1'b0}}};
            hi_q     <= {1'b0, base_unit, {UNIT_LG{1'b0}}}
                      + {1'b0, span_units, {UNIT_LG{1'b0}}};
        end
    end

    // Result pulses: refusal in the cycle after acceptance, else at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            prog_err  <= 1'b0;
            erase_err <= 1'b0;
        end else begin
            done      <= reject || finish;
            prog_err  <= (reject && op_in == OP_PROG)
                       || (finish && !end_ok && op_q == OP_PROG);
            erase_err <= (reject && op_in == OP_ERASE)
                       || (finish && !end_ok && op_q == OP_ERASE);
        end
    end

    assign even_q = {addr_q[AW-1:1], 1'b0};
    assign odd_q  = {addr_q[AW-1:1], 1'b1};

    // Apply the finished operation to the array in one edge.
    always_ff @(posedge clk) begin
        if (commit) begin
            if (op_q == OP_PROG) begin
                if (word_q) begin
                    mem[even_q] <= mem[even_q] & data_q[7:0];
                    mem[odd_q]  <= mem[odd_q]  & data_q[15:8];
                end else begin
                    mem[addr_q] <= mem[addr_q] & data_q[7:0];
                end
            end else begin
                for (int i = 0; i < MEM_BYTES; i++) begin
                    if ((AW+1)'(i) >= lo_q && (AW+1)'(i) < hi_q)
                        mem[i] <= 8'hFF;
                end
            end
        end
    end

    assign rd_even = {rd_addr[AW-1:1], 1'b0};
    assign rd_odd  = {rd_addr[AW-1:1], 1'b1};

    // Combinational read port, byte or word wide.
    always_comb begin
        if (rd_word)
            rd_data = {mem[rd_odd], mem[rd_even]};
        else
            rd_data = {8'h00, mem[rd_addr]};
    end

    // R9: every fall of busy is a completion and carries done.
    a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done is only reported while idle.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: error flags only accompany done, and never both at once.
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err || erase_err) |-> (done && !(prog_err && erase_err)));

    // R6: the boot region is only changed while an unlock is present.
    a_r6_boot_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && region_q == REG_BOOT) |-> (unlock_hv || wp_hi));

    // R8: no commit without a valid programming supply.
    a_r8_supply_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> vpp_ok);

    // R10: the captured request stays put while it runs.
    a_r10_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> ($stable(addr_q) && $stable(op_q) && $stable(data_q)));

endmodule

// File: tb/fbk_flash_array_test.sv
// Self-checking bench: drives a top-boot and a bottom-boot instance with the
// same requests and compares them against a byte model built from the rules.
module fbk_flash_array_test;

    localparam int UNIT_LG = 6;
    localparam int AW      = UNIT_LG + 5;
    localparam int MEMB    = 1 << AW;
    localparam int PC      = 3;
    localparam int EC      = 7;
    localparam int LOOPN   = EC + 3;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_word, vpp_ok, unlock_hv, wp_hi, rd_word;
    logic [1:0] req_op;
    logic [AW-1:0] req_addr, rd_addr;
    logic [15:0] req_data;
    logic [15:0] rdat [2];
    logic busy_s [2], done_s [2], perr_s [2], eerr_s [2];

    logic [7:0] mdl [2][MEMB];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fbk_flash_array #(.UNIT_LG(UNIT_LG), .TOP_BOOT(1'b1), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_word(req_word), .req_data(req_data), .vpp_ok(vpp_ok), .unlock_hv(unlock_hv),
        .wp_hi(wp_hi), .rd_addr(rd_addr), .rd_word(rd_word), .rd_data(rdat[0]),
        .busy(busy_s[0]), .done(done_s[0]), .prog_err(perr_s[0]), .erase_err(eerr_s[0]));

    fbk_flash_array #(.UNIT_LG(UNIT_LG), .TOP_BOOT(1'b0), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut_bot (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_word(req_word), .req_data(req_data), .vpp_ok(vpp_ok), .unlock_hv(unlock_hv),
        .wp_hi(wp_hi), .rd_addr(rd_addr), .rd_word(rd_word), .rd_data(rdat[1]),
        .busy(busy_s[1]), .done(done_s[1]), .prog_err(perr_s[1]), .erase_err(eerr_s[1]));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Region rules from R2 (inst 0) and R3 (inst 1), in units.
    function automatic int f_base(input int inst, input int a);
        int u = a >> UNIT_LG;
        if (inst == 0) begin
            if (u >= 30) return 30 << UNIT_LG;
            if (u == 29) return 29 << UNIT_LG;
            if (u == 28) return 28 << UNIT_LG;
            if (u >= 16) return 16 << UNIT_LG;
            return 0;
        end
        if (u < 2)  return 0;
        if (u == 2) return 2 << UNIT_LG;
        if (u == 3) return 3 << UNIT_LG;
        if (u < 16) return 4 << UNIT_LG;
        return 16 << UNIT_LG;
    endfunction

    function automatic int f_span(input int inst, input int a);
        int u = a >> UNIT_LG;
        if (inst == 0) begin
            if (u >= 30) return 2 << UNIT_LG;
            if (u >= 28) return 1 << UNIT_LG;
            if (u >= 16) return 12 << UNIT_LG;
            return 16 << UNIT_LG;
        end
        if (u < 2)  return 2 << UNIT_LG;
        if (u < 4)  return 1 << UNIT_LG;
        if (u < 16) return 12 << UNIT_LG;
        return 16 << UNIT_LG;
    endfunction

    function automatic bit f_boot(input int inst, input int a);
        int u = a >> UNIT_LG;
        return (inst == 0) ? (u >= 30) : (u < 2);
    endfunction

    function automatic int f_read(input int inst, input int a, input bit w);
        int e = a & ~1;
        if (w) return {mdl[inst][e + 1], mdl[inst][e]};
        return {8'h00, mdl[inst][a]};
    endfunction

    // R11: read one address from both instances and compare.
    task automatic chk_read(input int a, input bit w, input string tag);
        rd_addr = AW'(a);
        rd_word = w;
        #1;
        for (int i = 0; i < 2; i++)
            chk(tag, $sformatf("R11 read inst%0d addr %0h w%0d", i, a, w), rdat[i], f_read(i, a, w));
    endtask

    // R2 R3 R5: sweep the whole array of both instances.
    task automatic full_cmp(input string tag);
        int bad [2];
        int first [2];
        bad = '{0, 0};
        first = '{-1, -1};
        rd_word = 1'b0;
        for (int a = 0; a < MEMB; a++) begin
            rd_addr = AW'(a);
            #1;
            for (int i = 0; i < 2; i++)
                if (rdat[i] != {8'h00, mdl[i][a]}) begin
                    bad[i]++;
                    if (first[i] < 0) first[i] = a;
                end
        end
        for (int i = 0; i < 2; i++) begin
            if (bad[i] != 0 && first[i] >= 0)
                chk(tag, $sformatf("sweep inst%0d first bad addr %0h", i, first[i]),
                    rdat[i], {8'h00, mdl[i][first[i]]});
            chk(tag, $sformatf("sweep inst%0d mismatching bytes", i), bad[i], 0);
        end
    endtask

    // One request, with optional unlock drop at loop step drop_at and an
    // injected second request while busy; checks timing, flags and data.
    task automatic run_op(input int op, input int addr, input bit word, input int data,
                          input bit hv, input bit wp, input bit vpp,
                          input int drop_at, input bit inject, input int nrand);
        int  nbusy [2], ndone [2], nperr [2], neerr [2];
        bit  legal, allow, lost, ok;
        int  lat, b0, sp;
        nbusy = '{0, 0}; ndone = '{0, 0}; nperr = '{0, 0}; neerr = '{0, 0};
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr); req_word = word;
        req_data = data[15:0]; unlock_hv = hv; wp_hi = wp; vpp_ok = vpp;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < LOOPN; j++) begin
            for (int i = 0; i < 2; i++) begin
                nbusy[i] += int'(busy_s[i]);
                ndone[i] += int'(done_s[i]);
                nperr[i] += int'(perr_s[i]);
                neerr[i] += int'(eerr_s[i]);
            end
            if (j == drop_at) begin unlock_hv = 1'b0; wp_hi = 1'b0; end
            if (inject && j == 0) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr = AW'(addr ^ 8); req_word = 1'b1;
                req_data = 16'h0000;
            end
            if (inject && j == 1) req_valid = 1'b0;
            @(negedge clk);
        end
        legal = (op == 1) || (op == 2);
        lat   = (op == 2) ? EC : PC;
        for (int i = 0; i < 2; i++) begin
            allow = legal && vpp && (!f_boot(i, addr) || hv || wp);
            lost  = (drop_at >= 0) && (drop_at < lat) && f_boot(i, addr);
            ok    = allow && !lost;
            chk("R9", $sformatf("busy cycles inst%0d op%0d", i, op), nbusy[i], allow ? lat : 0);
            chk("R10", $sformatf("done pulses inst%0d op%0d", i, op), ndone[i], legal ? 1 : 0);
            chk("R6", $sformatf("prog_err inst%0d", i), nperr[i], (op == 1 && !ok) ? 1 : 0);
            chk("R7", $sformatf("erase_err inst%0d", i), neerr[i], (op == 2 && !ok) ? 1 : 0);
            if (ok && op == 1) begin
                if (word) begin
                    mdl[i][addr & ~1]       = mdl[i][addr & ~1] & data[7:0];
                    mdl[i][(addr & ~1) + 1] = mdl[i][(addr & ~1) + 1] & data[15:8];
                end else begin
                    mdl[i][addr] = mdl[i][addr] & data[7:0];
                end
            end
            if (ok && op == 2) begin
                b0 = f_base(i, addr);
                sp = f_span(i, addr);
                for (int b = b0; b < b0 + sp; b++) mdl[i][b] = 8'hFF;
            end
        end
        if (nrand >= 0) begin
            chk_read(addr, 1'b1, "R4");
            chk_read(addr, 1'b0, "R4");
            if (inject) chk_read(addr ^ 8, 1'b1, "R10");
            for (int k = 0; k < nrand; k++) chk_read(int'($urandom % MEMB), 1'($urandom), "R11");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int probes [8] = '{0, 2, 3, 4, 16, 28, 29, 30};
        int r;
        void'($urandom(32'd20250611));
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_word = 1'b0;
        req_data = '0; vpp_ok = 1'b1; unlock_hv = 1'b0; wp_hi = 1'b0; rd_addr = '0; rd_word = 1'b0;
        repeat (3) @(negedge clk);
        // R1: control outputs quiet in reset and right after.
        for (int i = 0; i < 2; i++) begin
            chk("R1", "busy", busy_s[i], 0);
            chk("R1", "done", done_s[i], 0);
            chk("R1", "errors", {perr_s[i], eerr_s[i]}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++) chk("R1", "busy after reset", busy_s[i], 0);

        // R5: bring every region of both maps to the erased state.
        foreach (probes[p]) run_op(2, probes[p] << UNIT_LG, 0, 0, 0, 1, 1, -1, 0, -1);
        full_cmp("R5 initial erase");

        // R11: clear the whole array with word programs under the unlock flag.
        for (int a = 0; a < MEMB; a += 2) run_op(1, a, 1, 0, 1, 0, 1, -1, 0, -1);
        full_cmp("R11 fill");

        // R2 R3: erase one region at a time and sweep for exact bounds.
        foreach (probes[p]) begin
            run_op(2, (probes[p] << UNIT_LG) + 5, 0, 0, 0, 1, 1, -1, 0, 0);
            full_cmp("R2 R3 region bounds");
        end

        // R4: two byte programs AND together.
        run_op(1, (5 << UNIT_LG) + 7, 0, 'hA5, 0, 0, 1, -1, 0, 0);
        run_op(1, (5 << UNIT_LG) + 7, 0, 'h3C, 0, 0, 1, -1, 0, 0);
        rd_addr = AW'((5 << UNIT_LG) + 7); rd_word = 1'b0; #1;
        chk("R4", "AND result top", rdat[0], 16'h0024);
        chk("R4", "AND result bottom", rdat[1], 16'h0024);

        // R6: boot regions locked, then each unlock source alone.
        run_op(1, (31 << UNIT_LG) + 2, 1, 'h1234, 0, 0, 1, -1, 0, 0);
        run_op(1, (1 << UNIT_LG) + 2, 1, 'h00F0, 0, 0, 1, -1, 0, 0);
        run_op(2, (1 << UNIT_LG), 0, 0, 0, 0, 1, -1, 0, 0);
        run_op(1, (31 << UNIT_LG) + 4, 1, 'h8001, 0, 1, 1, -1, 0, 0);
        run_op(1, (1 << UNIT_LG) + 6, 0, 'h7E, 1, 0, 1, -1, 0, 0);

        // R7: unlock lapses mid-operation.
        run_op(2, (30 << UNIT_LG), 0, 0, 0, 1, 1, 2, 0, 0);
        run_op(1, 9, 0, 'h00, 1, 0, 1, 1, 0, 0);
        run_op(1, (31 << UNIT_LG) + 9, 0, 'h00, 1, 1, 1, PC - 1, 0, 0);

        // R8: no supply, all regions refused.
        run_op(1, (10 << UNIT_LG), 1, 'h0000, 1, 1, 0, -1, 0, 0);
        run_op(2, (20 << UNIT_LG), 0, 0, 1, 1, 0, -1, 0, 0);

        // R10: request while busy, and the two ignored op codes.
        run_op(1, (10 << UNIT_LG) + 16, 1, 'hFF00, 0, 0, 1, -1, 1, 0);
        run_op(2, (12 << UNIT_LG) + 16, 0, 0, 0, 0, 1, -1, 1, 0);
        run_op(3, (12 << UNIT_LG), 0, 0, 1, 1, 1, -1, 0, 0);
        run_op(0, (12 << UNIT_LG), 0, 0, 1, 1, 1, -1, 0, 0);
        full_cmp("R10 ignored");

        // Mixed random traffic.
        for (int n = 0; n < 400; n++) begin
            int op;
            r = int'($urandom % 20);
            op = (r < 14 || r == 19) ? 1 : (r < 17) ? 2 : (r == 17) ? 3 : 0;
            run_op(op, int'($urandom % MEMB), 1'($urandom), int'($urandom & 32'hFFFF),
                   ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 10) != 0,
                   (($urandom % 8) == 0) ? int'($urandom % EC) : -1, 1'b0, 3);
        end
        full_cmp("R4 R5 random");

        summary();
        $finish;
    end

endmodule